// File: doc/BRIEF.md
# Two-Wire Output-Enable Write Slave

This block is a write-only slave on a two-wire serial bus. It holds a small bank of output-enable bytes that gate clock outputs elsewhere on the chip. The clock and data lines are brought into the system clock domain through a synchronizer. The system clock must run at least eight times faster than the serial clock. Start and stop conditions are detected from the synchronized levels.

A write transaction opens with a start condition. The first byte is the address byte, which must equal 0xD2: the seven address bits 1101001 followed by a write bit of 0. Next come two dummy bytes, a command code and then a byte count. The slave acknowledges both dummy bytes but does not use their values. Data bytes follow. They fill the enable registers strictly in order, starting with register 0. The slave drives the data line through an open-drain enable: when `sda_oe` is high, the pad pulls the line low.

Register 0 holds eight enable bits. Register 1 holds two enable bits in positions 7:6, and its other six bits are reserved and always read as zero. Every enable bit is 1 after reset. A stop condition or a repeated start ends the current transaction at any point, and a byte that was only partly received is dropped.

Top module: `twi_enable_slave`

## Requirements
- R1: After reset, `enables` equals 0xC0FF (register 0 = 0xFF in bits 7:0, register 1 = 0xC0 in bits 15:8) and `sda_oe` is low.
- R2: The address byte 0xD2 (address 7'h69, write bit 0) is acknowledged: `sda_oe` pulls the line low during the ninth clock of that byte.
- R3: An address byte other than 0xD2 or 0xD3 is not acknowledged. The slave then ignores every byte until the next start: it sends no acknowledge and writes no register.
- R4: A read request to the device address (byte 0xD3) is not acknowledged, and the bytes that follow change no register.
- R5: The two bytes after the address (command code and byte count) are acknowledged, and their values never change any register.
- R6: The first data byte is written to `enables[7:0]` and the second to `enables[15:8]`. A register is written only when all eight bits of its byte have been received.
- R7: Bits 5:0 of register 1 (`enables[13:8]`) are always 0, whatever value is written to them.
- R8: Data bytes after the second are acknowledged and discarded.
- R9: A stop or a repeated start ends the transaction and leaves a partly received byte uncommitted. A new transaction that opens with a repeated start works normally.
- R10: `sda_oe` rises only while SCL is low, is low in the cycle after a detected stop, and is low whenever the bus is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pull data line low when 1 (open-drain) |
| enables | output | 16 | Register 1 in bits 15:8, register 0 in bits 7:0 |

## Verification
The assertions check on every cycle that the reserved bits of register 1 stay zero and that the enables change only right after a falling SCL edge. They also check that the acknowledge drive switches on only while SCL is low and is released by a stop. Only the bench scenarios can show that the address is decoded correctly and that the dummy bytes are skipped. The same holds for the order in which data fills the registers, the dropping of extra bytes and the handling of truncated bytes. For these, the bench sweeps all 128 address values and many data and dummy patterns, and it compares the acknowledge bits and the final register values with values it computes itself.

// File: rtl/twi_enable_pkg.sv
package twi_enable_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SHIFT = 2'd1,
        PH_ACK   = 2'd2,
        PH_SKIP  = 2'd3
    } phase_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int   STAGES    = 2,
    parameter logic IDLE_LVL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] pipe_q, pipe_d;

    always_comb begin
        pipe_d = {pipe_q[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {(STAGES+1){IDLE_LVL}};
        else        pipe_q <= pipe_d;
    end

    assign level = pipe_q[STAGES-1];
    assign rise  =  pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall  = ~pipe_q[STAGES-1] &  pipe_q[STAGES];
endmodule

// File: rtl/twi_enable_bank.sv
module twi_enable_bank #(
    parameter int               NREG      = 2,
    parameter logic [NREG*8-1:0] RESET_VAL = 16'hC0FF,
    parameter logic [NREG*8-1:0] KEEP_MASK = 16'hC0FF,
    localparam int              IDXW      = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDXW-1:0]     wr_idx,
    input  logic [7:0]          wr_data,
    output logic [NREG*8-1:0]   bits_o
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [7:0] val_d, val_q;

        always_comb begin
            val_d = val_q;
            if (wr_en && (wr_idx == IDXW'(g)))
                val_d = wr_data & KEEP_MASK[g*8 +: 8];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) val_q <= RESET_VAL[g*8 +: 8];
            else        val_q <= val_d;
        end

        assign bits_o[g*8 +: 8] = val_q;
    end
endmodule

// File: rtl/twi_enable_slave.sv
module twi_enable_slave
    import twi_enable_pkg::*;
#(
    parameter logic [6:0]           DEV_ADDR    = 7'h69,
    parameter int                   DUMMY_BYTES = 2,
    parameter int                   NUM_REGS    = 2,
    parameter logic [NUM_REGS*8-1:0] RESET_VAL  = 16'hC0FF,
    parameter logic [NUM_REGS*8-1:0] WRITE_MASK = 16'hC0FF,
    parameter int                   SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe,
    output logic [NUM_REGS*8-1:0]  enables
);
    localparam int CNT_MAX = DUMMY_BYTES + NUM_REGS;
    localparam int CNTW    = $clog2(CNT_MAX + 1);
    localparam int IDXW    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    typedef struct packed {
        phase_e          phase;
        logic [3:0]      bits;
        logic [7:0]      shreg;
        logic            is_addr;
        logic [CNTW-1:0] cnt;
        logic            oe;
    } slave_state_t;

    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;
    logic start_det, stop_det;

    twi_line_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .din(scl_i),
        .level(scl_lvl), .rise(scl_rise), .fall(scl_fall)
    );

    twi_line_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .din(sda_i),
        .level(sda_lvl), .rise(sda_rise), .fall(sda_fall)
    );

    assign start_det = scl_lvl & sda_fall;
    assign stop_det  = scl_lvl & sda_rise;

    slave_state_t st_d, st_q;
    logic            wr_en;
    logic [IDXW-1:0] wr_idx;

    always_comb begin
        st_d   = st_q;
        wr_en  = 1'b0;
        wr_idx = '0;
        if (stop_det) begin
            st_d.phase = PH_IDLE;
            st_d.oe    = 1'b0;
        end else if (start_det) begin
            st_d.phase   = PH_SHIFT;
            st_d.bits    = '0;
            st_d.is_addr = 1'b1;
            st_d.cnt     = '0;
            st_d.oe      = 1'b0;
        end else begin
            case (st_q.phase)
                PH_SHIFT: begin
                    if (scl_rise && st_q.bits < 4'd8) begin
                        st_d.shreg = {st_q.shreg[6:0], sda_lvl};
                        st_d.bits  = st_q.bits + 4'd1;
                    end else if (scl_fall && st_q.bits == 4'd8) begin
                        if (st_q.is_addr) begin
                            if (st_q.shreg == {DEV_ADDR, 1'b0}) begin
                                st_d.phase = PH_ACK;
                                st_d.oe    = 1'b1;
                            end else begin
                                st_d.phase = PH_SKIP;
                            end
                        end else begin
                            st_d.phase = PH_ACK;
                            st_d.oe    = 1'b1;
                            if (st_q.cnt >= CNTW'(DUMMY_BYTES) &&
                                st_q.cnt <  CNTW'(CNT_MAX)) begin
                                wr_en  = 1'b1;
                                wr_idx = IDXW'(st_q.cnt - CNTW'(DUMMY_BYTES));
                            end
                            if (st_q.cnt < CNTW'(CNT_MAX))
                                st_d.cnt = st_q.cnt + CNTW'(1);
                        end
                    end
                end
                PH_ACK: begin
                    if (scl_fall) begin
                        st_d.oe      = 1'b0;
                        st_d.bits    = '0;
                        st_d.is_addr = 1'b0;
                        st_d.phase   = PH_SHIFT;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, bits: '0, shreg: '0,
                      is_addr: 1'b0, cnt: '0, oe: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    twi_enable_bank #(
        .NREG(NUM_REGS), .RESET_VAL(RESET_VAL), .KEEP_MASK(WRITE_MASK)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(st_q.shreg), .bits_o(enables)
    );

    assign sda_oe = st_q.oe;
endmodule

// File: rtl/twi_enable_slave_chk.sv
module twi_enable_slave_chk #(
    parameter int           W    = 16,
    parameter logic [W-1:0] MASK = 16'hC0FF
) (
    input logic         clk,
    input logic         rst_n,
    input logic         scl_lvl,
    input logic         scl_fall,
    input logic         start_det,
    input logic         stop_det,
    input logic         sda_oe,
    input logic [W-1:0] enables
);
    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (enables & ~MASK) == '0);

    assert_write_after_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enables != $past(enables)) |-> $past(scl_fall));

    assert_ack_rise_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_lvl);

    assert_ack_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> (!scl_lvl || $past(stop_det || start_det)));

    assert_stop_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);
endmodule

bind twi_enable_slave twi_enable_slave_chk #(
    .W(NUM_REGS*8), .MASK(WRITE_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .sda_oe(sda_oe), .enables(enables)
);

// File: tb/twi_enable_slave_test.sv
module twi_enable_slave_test;
    localparam int Q = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic [15:0] enables;
    logic        sda_bus;

    int checks = 0;
    int fails  = 0;
    logic [15:0] exp_en;

    always #10 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    twi_enable_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe(sda_oe), .enables(enables)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq(); wq();
    endtask

    task automatic send_bit(input logic b);
        wq();
        sda_m = b; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        wq();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        ack = ~sda_bus; wq();
        scl_m = 1'b0;
    endtask

    logic ack;

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R1: reset state
        exp_en = 16'hC0FF;
        chk("R1 reset enables", enables, exp_en);
        chk("R1 reset sda_oe", {15'd0, sda_oe}, 16'd0);

        // R2 R5 R6 R7: sweep of dummy and data values
        for (int i = 0; i < 16; i++) begin
            logic [7:0] d0, d1;
            d0 = 8'(i * 17) ^ 8'hA5;
            d1 = ~8'(i * 29 + 64);
            bus_start();
            send_byte(8'hD2, ack); chk("R2 address ack", {15'd0, ack}, 16'd1);
            send_byte(8'(i), ack); chk("R5 command ack", {15'd0, ack}, 16'd1);
            send_byte(8'(255 - i), ack); chk("R5 count ack", {15'd0, ack}, 16'd1);
            send_byte(d0, ack); chk("R6 data0 ack", {15'd0, ack}, 16'd1);
            send_byte(d1, ack); chk("R6 data1 ack", {15'd0, ack}, 16'd1);
            bus_stop();
            exp_en = {d1 & 8'hC0, d0};
            chk("R6 R7 register contents", enables, exp_en);
            chk("R10 idle after stop", {15'd0, sda_oe}, 16'd0);
        end

        // R7: all ones into register 1
        bus_start();
        send_byte(8'hD2, ack); send_byte(8'h00, ack); send_byte(8'h02, ack);
        send_byte(8'h0F, ack); send_byte(8'hFF, ack);
        bus_stop();
        exp_en = 16'hC00F;
        chk("R7 reserved bits stay zero", enables, exp_en);

        // R8: extra bytes acknowledged and dropped
        bus_start();
        send_byte(8'hD2, ack); send_byte(8'h11, ack); send_byte(8'h06, ack);
        send_byte(8'h3C, ack); send_byte(8'h40, ack);
        for (int k = 0; k < 4; k++) begin
            send_byte(8'h00 + 8'(k), ack);
            chk("R8 extra byte ack", {15'd0, ack}, 16'd1);
        end
        bus_stop();
        exp_en = 16'h403C;
        chk("R8 extra bytes discarded", enables, exp_en);

        // R5: only dummy bytes
        bus_start();
        send_byte(8'hD2, ack); send_byte(8'hFF, ack); send_byte(8'hFF, ack);
        bus_stop();
        chk("R5 dummy bytes write nothing", enables, exp_en);

        // R3 R4: full address sweep
        for (int a = 0; a < 128; a++) begin
            logic [7:0] ab;
            ab = {7'(a), 1'b0};
            bus_start();
            send_byte(ab, ack);
            chk("R2 R3 address decode", {15'd0, ack}, {15'd0, (a == 7'h69)});
            if (a != 7'h69) begin
                send_byte(8'h00, ack);
                chk("R3 ignored byte no ack", {15'd0, ack}, 16'd0);
            end
            bus_stop();
        end
        chk("R3 registers unchanged", enables, exp_en);

        // R3: wrong address then data-like bytes
        bus_start();
        send_byte(8'hD0, ack); send_byte(8'h00, ack); send_byte(8'h00, ack);
        send_byte(8'h00, ack); send_byte(8'h00, ack);
        chk("R3 trailing byte no ack", {15'd0, ack}, 16'd0);
        bus_stop();
        chk("R3 no write after mismatch", enables, exp_en);

        // R4: read request
        bus_start();
        send_byte(8'hD3, ack);
        chk("R4 read not acked", {15'd0, ack}, 16'd0);
        send_byte(8'h00, ack); send_byte(8'h00, ack); send_byte(8'h00, ack);
        bus_stop();
        chk("R4 read writes nothing", enables, exp_en);

        // R9: partial byte then stop
        bus_start();
        send_byte(8'hD2, ack); send_byte(8'h00, ack); send_byte(8'h02, ack);
        send_byte(8'h11, ack);
        for (int k = 0; k < 4; k++) send_bit(1'b0);
        bus_stop();
        exp_en = {exp_en[15:8], 8'h11};
        chk("R9 partial byte dropped at stop", enables, exp_en);
        chk("R9 released after stop", {15'd0, sda_oe}, 16'd0);

        // R9: partial byte then repeated start, new transaction
        bus_start();
        send_byte(8'hD2, ack); send_byte(8'h00, ack); send_byte(8'h02, ack);
        for (int k = 0; k < 3; k++) send_bit(1'b1);
        bus_rstart();
        chk("R9 repeated start keeps registers", enables, exp_en);
        send_byte(8'hD2, ack); chk("R9 address after rstart", {15'd0, ack}, 16'd1);
        send_byte(8'h55, ack); send_byte(8'h02, ack);
        send_byte(8'h77, ack); send_byte(8'h80, ack);
        bus_stop();
        exp_en = 16'h8077;
        chk("R9 new transaction writes", enables, exp_en);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule